// File: doc/BRIEF.md
# Segment-Pair Memory Access Checker

This block sits beside a 32-bit processor's memory port and judges every access before it proceeds. Software first programs a small table of address ranges (segments) that together cover the parts of the address space it wants to make reachable. It then programs a matrix of rights that says, for each ordered pair of segments, whether code running in the first segment may read, write or execute the second. Because the matrix is indexed by the pair, a segment can hold different rights over each of the other segments and over itself.

For each request the block takes the instruction address, the access address and the access kind. It locates both segments by comparing each address against every range at once, with no selector field in the request. One cycle later it returns either a grant or a violation. A violation carries a cause code and the address that caused it. Instruction fetches are judged as execute access of the fetch address by its own segment. Loads are judged as read access and stores as write access.

The tables are written through a simple register-style configuration port. Reset leaves both tables empty, so every access faults until software sets them up.

Top module: `seg_check`

## Requirements
- R1: After reset every segment entry is invalid, so any request faults with cause 0 (no segment) and `rsp_valid` is low until a request is made.
- R2: An address belongs to a valid segment entry when base <= address <= limit, both bounds inclusive. The segment is found from the address alone.
- R3: When several valid entries match an address, the entry with the lowest index is used.
- R4: The rights are read from the entry at index {source segment, target segment}, i.e. source*8+target. The entry bits are bit0 = read, bit1 = write and bit2 = execute.
- R5: Request kinds 0 and 3 are instruction fetches. A fetch uses `req_addr` as both source and target address, ignores `req_pc`, and needs the execute right.
- R6: Kind 1 (load) needs the read right and kind 2 (store) needs the write right, both with `req_pc` giving the source segment. A missing right faults with cause 1 for a load, 2 for a store and 3 for a fetch.
- R7: If either address matches no valid segment, the request faults with cause 0, whatever the rights say. The fault address is then the source address if the source missed, otherwise the target address.
- R8: On a rights fault the captured fault address is `req_addr`.
- R9: The response arrives exactly one cycle after the request. `rsp_valid` follows `req_valid`, and exactly one of `rsp_grant`/`rsp_fault` is high while `rsp_valid` is high; both are low otherwise.
- R10: A configuration write takes effect for the next request. A request in the same cycle as a write is judged with the old table contents.
- R11: `rsp_fault_addr` changes only when a fault is reported and holds its value through grants and idle cycles.
- R12: After reset every rights entry is clear, so a request whose segments are valid but whose rights were never written faults on rights.
- R13: Configuration writes use `cfg_sel` 0 = base, 1 = limit, 2 = valid (bit 0 of data) on entry `cfg_addr[2:0]`, and `cfg_sel` 3 = rights on entry `cfg_addr`, data bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0/3 fetch, 1 load, 2 store |
| req_pc | input | 32 | Address of the executing instruction |
| req_addr | input | 32 | Access (or fetch) address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Which field to write |
| cfg_addr | input | 6 | Segment index (low bits) or rights pair index |
| cfg_wdata | input | 32 | Configuration write data |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access denied |
| rsp_cause | output | 2 | 0 no segment, 1 read, 2 write, 3 execute |
| rsp_fault_addr | output | 32 | Address that caused the latest fault |

## Verification
A check and a table write can land in the same cycle. The bench provokes this by driving a request and a write on the same falling edge. In one case the write clears the rights that the request depends on. In the other it invalidates the segment that the request hits. The response to that request must show the old contents (a grant), and an identical request on the next cycle must show the new contents: a read fault in the first case and a no-segment fault in the second.

// File: rtl/seg_pkg.sv
package seg_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH     = 2'd0,
        KIND_LOAD      = 2'd1,
        KIND_STORE     = 2'd2,
        KIND_FETCH_ALT = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        CAUSE_NOSEG = 2'd0,
        CAUSE_READ  = 2'd1,
        CAUSE_WRITE = 2'd2,
        CAUSE_EXEC  = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        SEL_BASE   = 2'd0,
        SEL_LIMIT  = 2'd1,
        SEL_VALID  = 2'd2,
        SEL_RIGHTS = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic exec;
        logic wr;
        logic rd;
    } rights_t;

    function automatic logic is_fetch(kind_e k);
        return (k == KIND_FETCH) || (k == KIND_FETCH_ALT);
    endfunction

    function automatic rights_t needed_right(kind_e k);
        rights_t r;
        r = '0;
        case (k)
            KIND_LOAD:  r.rd   = 1'b1;
            KIND_STORE: r.wr   = 1'b1;
            default:    r.exec = 1'b1;
        endcase
        return r;
    endfunction

    function automatic cause_e rights_cause(kind_e k);
        case (k)
            KIND_LOAD:  return CAUSE_READ;
            KIND_STORE: return CAUSE_WRITE;
            default:    return CAUSE_EXEC;
        endcase
    endfunction

endpackage

// File: rtl/seg_prio.sv
module seg_prio #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  match,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/seg_table.sv
module seg_table #(
    parameter int NSEG = 8,
    parameter int AW   = 32,
    parameter int IW   = $clog2(NSEG)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  seg_pkg::cfg_sel_e   wr_sel,
    input  logic [IW-1:0]       wr_idx,
    input  logic [AW-1:0]       wr_data,
    input  logic [AW-1:0]       addr_a,
    input  logic [AW-1:0]       addr_b,
    output logic                hit_a,
    output logic [IW-1:0]       idx_a,
    output logic                hit_b,
    output logic [IW-1:0]       idx_b
);
    import seg_pkg::*;

    logic [AW-1:0]   base_q  [NSEG];
    logic [AW-1:0]   limit_q [NSEG];
    logic [NSEG-1:0] valid_q;
    logic [NSEG-1:0] match_a;
    logic [NSEG-1:0] match_b;

    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[g]  <= '0;
                limit_q[g] <= '0;
                valid_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                case (wr_sel)
                    SEL_BASE:  base_q[g]  <= wr_data;
                    SEL_LIMIT: limit_q[g] <= wr_data;
                    SEL_VALID: valid_q[g] <= wr_data[0];
                    default:   ;
                endcase
            end
        end

        assign match_a[g] = valid_q[g] && (addr_a >= base_q[g]) && (addr_a <= limit_q[g]);
        assign match_b[g] = valid_q[g] && (addr_b >= base_q[g]) && (addr_b <= limit_q[g]);
    end

    seg_prio #(.N(NSEG), .IW(IW)) u_prio_a (.match(match_a), .hit(hit_a), .idx(idx_a));
    seg_prio #(.N(NSEG), .IW(IW)) u_prio_b (.match(match_b), .hit(hit_b), .idx(idx_b));

    // R1: the cycle after reset no entry may match
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!hit_a && !hit_b));

endmodule

// File: rtl/rights_table.sv
module rights_table #(
    parameter int NSEG = 8,
    parameter int IW   = $clog2(NSEG),
    localparam int PW  = 2 * IW,
    localparam int NP  = NSEG * NSEG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_idx,
    input  seg_pkg::rights_t  wr_data,
    input  logic [PW-1:0]     rd_idx,
    output seg_pkg::rights_t  rd_data
);
    import seg_pkg::*;

    rights_t mem_q [NP];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NP; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];

    // R12: every pair reads back empty right after reset
    assert_reset_clear_R12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data == '0));

endmodule

// File: rtl/seg_check.sv
module seg_check #(
    parameter int NSEG = 8,
    parameter int AW   = 32,
    localparam int IW  = $clog2(NSEG),
    localparam int PW  = 2 * IW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_pc,
    input  logic [AW-1:0] req_addr,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [PW-1:0] cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    output logic          rsp_valid,
    output logic          rsp_grant,
    output logic          rsp_fault,
    output logic [1:0]    rsp_cause,
    output logic [AW-1:0] rsp_fault_addr
);
    import seg_pkg::*;

    kind_e    kind;
    cfg_sel_e sel;
    logic     fetch;
    logic [AW-1:0] src_addr;

    logic          src_hit, tgt_hit;
    logic [IW-1:0] src_idx, tgt_idx;
    rights_t       pair_rights;
    rights_t       need;

    logic          seg_we, rt_we;
    logic          fault_c;
    cause_e        cause_c;
    logic [AW-1:0] faddr_c;

    assign kind     = kind_e'(req_kind);
    assign sel      = cfg_sel_e'(cfg_sel);
    assign fetch    = is_fetch(kind);
    assign src_addr = fetch ? req_addr : req_pc;
    assign need     = needed_right(kind);

    assign seg_we = cfg_we && (sel != SEL_RIGHTS);
    assign rt_we  = cfg_we && (sel == SEL_RIGHTS);

    seg_table #(.NSEG(NSEG), .AW(AW), .IW(IW)) u_segs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (seg_we),
        .wr_sel  (sel),
        .wr_idx  (cfg_addr[IW-1:0]),
        .wr_data (cfg_wdata),
        .addr_a  (src_addr),
        .addr_b  (req_addr),
        .hit_a   (src_hit),
        .idx_a   (src_idx),
        .hit_b   (tgt_hit),
        .idx_b   (tgt_idx)
    );

    rights_table #(.NSEG(NSEG), .IW(IW)) u_rights (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (rt_we),
        .wr_idx  (cfg_addr),
        .wr_data (rights_t'(cfg_wdata[2:0])),
        .rd_idx  ({src_idx, tgt_idx}),
        .rd_data (pair_rights)
    );

    always_comb begin
        fault_c = 1'b0;
        cause_c = CAUSE_NOSEG;
        faddr_c = req_addr;
        if (!src_hit) begin
            fault_c = 1'b1;
            faddr_c = src_addr;
        end else if (!tgt_hit) begin
            fault_c = 1'b1;
        end else if ((pair_rights & need) == '0) begin
            fault_c = 1'b1;
            cause_c = rights_cause(kind);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_grant      <= 1'b0;
            rsp_fault      <= 1'b0;
            rsp_cause      <= '0;
            rsp_fault_addr <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_grant <= req_valid && !fault_c;
            rsp_fault <= req_valid && fault_c;
            if (req_valid) rsp_cause <= cause_c;
            if (req_valid && fault_c) rsp_fault_addr <= faddr_c;
        end
    end

    // R9: one-cycle latency from request to response
    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_valid && !rst));

    // R9: exactly one verdict while valid, none otherwise
    assert_one_verdict_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid ? (rsp_grant != rsp_fault) : (!rsp_grant && !rsp_fault));

    // R7: a no-segment cause needs a lookup miss in the request cycle
    assert_noseg_miss_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault && rsp_cause == 2'd0) |-> $past(!src_hit || !tgt_hit));

    // R11: the captured address holds unless a fault is reported
    assert_faddr_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !rsp_fault |-> $stable(rsp_fault_addr));

endmodule

// File: tb/sim_seg_check.sv
module sim_seg_check;

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] pc;
        logic [31:0] addr;
        logic        fault;
        logic [1:0]  cause;
        logic [31:0] faddr;
    } vec_t;

    localparam int NV = 15;
    // Table: kind, pc, addr, fault, cause, fault address
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'hDEAD_BEEF, 32'h0000_1000, 1'b0, 2'd0, 32'h0},          // R5 fetch, pc ignored
        '{2'd1, 32'h0000_1004, 32'h0000_2000, 1'b0, 2'd0, 32'h0},          // R6 load granted
        '{2'd2, 32'h0000_1004, 32'h0000_2FFF, 1'b0, 2'd0, 32'h0},          // R2 limit inclusive
        '{2'd2, 32'h0000_3000, 32'h0000_2000, 1'b1, 2'd2, 32'h0000_2000},  // R6 write denied
        '{2'd1, 32'h0000_3000, 32'h0000_1000, 1'b1, 2'd1, 32'h0000_1000},  // R4 pair (2,0) empty
        '{2'd0, 32'h0000_0000, 32'h0000_2000, 1'b1, 2'd3, 32'h0000_2000},  // R5 exec denied
        '{2'd1, 32'h0000_1000, 32'h0000_4000, 1'b1, 2'd0, 32'h0000_4000},  // R7 target miss
        '{2'd1, 32'h0000_0500, 32'h0000_2000, 1'b1, 2'd0, 32'h0000_0500},  // R7 source miss
        '{2'd0, 32'h0000_0000, 32'h0000_1900, 1'b0, 2'd0, 32'h0},          // R3 lowest wins
        '{2'd1, 32'h0000_1900, 32'h0000_2100, 1'b0, 2'd0, 32'h0},          // R3 both overlapped
        '{2'd0, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 2'd0, 32'h0},          // R2 top of space
        '{2'd3, 32'h0000_0000, 32'h0000_3000, 1'b0, 2'd0, 32'h0},          // R5 kind 3, base
        '{2'd0, 32'h0000_0000, 32'h0000_0FFF, 1'b1, 2'd0, 32'h0000_0FFF},  // R2 below base
        '{2'd1, 32'h0000_1004, 32'h0000_1FFF, 1'b1, 2'd1, 32'h0000_1FFF},  // R4 (0,0) exec only
        '{2'd2, 32'h0000_1004, 32'h0000_3000, 1'b1, 2'd2, 32'h0000_3000}   // R8 rights fault addr
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [31:0] req_pc = '0;
    logic [31:0] req_addr = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rsp_valid, rsp_grant, rsp_fault;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_fault_addr;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] last_faddr = '0;

    always #4 clk = ~clk;

    seg_check u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_kind(req_kind), .req_pc(req_pc), .req_addr(req_addr),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .rsp_fault_addr(rsp_fault_addr)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(logic [1:0] s, logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_seg(int i, logic [31:0] lo, logic [31:0] hi);
        cfg_write(2'd0, 6'(i), lo);
        cfg_write(2'd1, 6'(i), hi);
        cfg_write(2'd2, 6'(i), 32'd1);
    endtask

    // drive on a falling edge, response registered at the next rising edge, sample at the falling edge after
    task automatic issue(logic [1:0] k, logic [31:0] pc, logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_pc = pc; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic expect_rsp(string tag, logic f, logic [1:0] c, logic [31:0] fa);
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " grant"}, 32'(rsp_grant), 32'(!f));
        check({tag, " fault"}, 32'(rsp_fault), 32'(f));
        if (f) begin
            check({tag, " cause"}, 32'(rsp_cause), 32'(c));
            check({tag, " faddr"}, rsp_fault_addr, fa);
            last_faddr = fa;
        end else begin
            check({tag, " faddr held R11"}, rsp_fault_addr, last_faddr);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", 32'(rsp_valid), 32'd0);

        // R1: empty segment table faults everything
        issue(2'd0, 32'h0, 32'h0000_1000);
        expect_rsp("R1", 1'b1, 2'd0, 32'h0000_1000);

        // R12: segment present, rights never written
        set_seg(0, 32'h0000_1000, 32'h0000_1FFF);
        issue(2'd0, 32'h0, 32'h0000_1000);
        expect_rsp("R12", 1'b1, 2'd3, 32'h0000_1000);

        // R13: program the rest of the tables
        set_seg(1, 32'h0000_2000, 32'h0000_2FFF);
        set_seg(2, 32'h0000_3000, 32'h0000_3FFF);
        set_seg(3, 32'h0000_1800, 32'h0000_27FF);
        set_seg(7, 32'hFFFF_F000, 32'hFFFF_FFFF);
        cfg_write(2'd3, 6'd0,  32'd4); // (0,0) exec
        cfg_write(2'd3, 6'd1,  32'd3); // (0,1) read+write
        cfg_write(2'd3, 6'd18, 32'd4); // (2,2) exec
        cfg_write(2'd3, 6'd17, 32'd1); // (2,1) read
        cfg_write(2'd3, 6'd63, 32'd5); // (7,7) exec+read

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].kind, VECS[i].pc, VECS[i].addr);
            expect_rsp($sformatf("vec%0d R2-set", i), VECS[i].fault, VECS[i].cause, VECS[i].faddr);
        end

        // R9: no request gives no response
        @(negedge clk);
        check("R9 idle", 32'({rsp_valid, rsp_grant, rsp_fault}), 32'd0);
        check("R11 idle hold", rsp_fault_addr, last_faddr);

        // R10: rights cleared in the same cycle as a load
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd1; req_pc = 32'h0000_1004; req_addr = 32'h0000_2000;
        cfg_we = 1'b1; cfg_sel = 2'd3; cfg_addr = 6'd1; cfg_wdata = 32'd0;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        expect_rsp("R10 old rights", 1'b0, 2'd0, 32'h0);
        issue(2'd1, 32'h0000_1004, 32'h0000_2000);
        expect_rsp("R10 new rights", 1'b1, 2'd1, 32'h0000_2000);

        // R10: segment invalidated in the same cycle as a fetch
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_pc = 32'h0; req_addr = 32'hFFFF_FFF0;
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_addr = 6'd7; cfg_wdata = 32'd0;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        expect_rsp("R10 old segment", 1'b0, 2'd0, 32'h0);
        issue(2'd0, 32'h0, 32'hFFFF_FFF0);
        expect_rsp("R10 new segment", 1'b1, 2'd0, 32'hFFFF_FFF0);

        // R10: restored rights work again on the next check
        cfg_write(2'd3, 6'd1, 32'd3);
        issue(2'd2, 32'h0000_1004, 32'h0000_2004);
        expect_rsp("R10 restored", 1'b0, 2'd0, 32'h0);

        report();
        $finish;
    end

endmodule